// File: doc/BRIEF.md
# Polled Device Controller Register Front End

This block is the register face of a peripheral controller that software operates by polling two status flags. A small addressed bus reaches a command register, a status register and a bank of data buffer registers. Writing a valid command while the controller is idle starts a device operation of fixed length. The operation is a counted delay that stands in for the real device. For its whole length the busy flag is high. When it ends, busy drops and done rises on the same clock edge. A read operation fills the buffer with a deterministic pattern. A write operation presents the buffer contents on an output port for one cycle.

Software has to acknowledge done before the controller takes another command. The controller has three legal flag states: idle, working and finished. Busy and done are never high together. A command that arrives at the wrong time, or carries an unknown opcode, changes nothing except an error code that software can read. Each command can ask for an interrupt request. That request is high while done is set and falls when software acknowledges.

Top module: `poll_dev_ctrl`

## Requirements
- R1: After reset the busy flag, done flag, error code, stored command, irq_o and out_valid_o are all 0, and every bus read returns 0.
- R2: A command write at address 0, with opcode wdata[1:0] equal to 1 (read) or 2 (write) and both flags clear, sets busy from the next cycle. Busy then stays high for exactly OP_CYCLES cycles, and busy and done are never both 1.
- R3: At the end of an operation, busy falls and done rises on the same clock edge.
- R4: A command write while busy or done is 1 starts nothing and leaves the stored command unchanged. It sets the error code to 1.
- R5: A command write with opcode 0 or 3 while idle starts nothing and sets the error code to 2.
- R6: A status write (address 1) with wdata bit 1 set clears done and the error code. Once done is clear, a new command is accepted.
- R7: When a read operation completes, data register i (address 2+i) becomes (k*NUM_BUF + i) mod 2^DATA_W. Here k is the number of operations completed before this one.
- R8: When a write operation completes, out_valid_o is high for exactly one cycle. In that cycle out_data_o holds the buffer, with register 0 in the least significant DATA_W bits.
- R9: irq_o is 1 exactly while done is 1 and the stored command has bit 4 (interrupt enable) set.
- R10: A read returns data in the cycle after bus_rd_i, and bus_rdata_o holds while no read is made. Status reads as bit 0 busy, bit 1 done, bits 7:4 error code. The command register reads back bits 1:0 opcode and bit 4 enable. Unmapped addresses read 0, and reads change no state.
- R11: Data register writes are ignored while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | BUS_W | Write data |
| bus_rdata_o | output | BUS_W | Read data, valid the cycle after a read |
| irq_o | output | 1 | Completion interrupt request |
| out_valid_o | output | 1 | One-cycle strobe when a write operation completes |
| out_data_o | output | NUM_BUF*DATA_W | Buffer contents delivered by a write operation |

## Verification
The bench sends commands while busy is high and while done is high. A controller with a loose handshake would restart, or overwrite the stored command, instead of reporting error 1. It also writes a data register in the middle of a write operation. A design that does not block that write would deliver the corrupted byte on out_data_o. It issues a bad opcode, and it runs a second read operation, so that a stale or wrong pattern base shows up in the data registers. It also checks that irq_o stays low for a command without enable and falls on acknowledge. An off-by-one operation counter would move the done edge away from where the reference model places it.

// File: rtl/devctl_pkg.sv
package devctl_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  localparam logic [3:0] ERR_NONE   = 4'd0;
  localparam logic [3:0] ERR_REJECT = 4'd1;
  localparam logic [3:0] ERR_BADOP  = 4'd2;

  localparam int CMD_ADDR  = 0;
  localparam int STAT_ADDR = 1;
  localparam int DATA_BASE = 2;
  localparam int IE_BIT    = 4;
  localparam int ACK_BIT   = 1;
endpackage

// File: rtl/devctl_seq.sv
module devctl_seq #(
  parameter int OP_CYCLES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ack_i,
  output logic busy_o,
  output logic done_o,
  output logic finish_o
);
  localparam int CNT_W = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign finish_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (start_i) begin
        busy_o <= 1'b1;
        cnt_q  <= CNT_W'(OP_CYCLES - 1);
      end else if (finish_o) begin
        busy_o <= 1'b0;
      end else if (busy_o) begin
        cnt_q <= cnt_q - 1'b1;
      end
      // completion wins over a same-edge acknowledge
      if (finish_o)   done_o <= 1'b1;
      else if (ack_i) done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/devctl_buf.sv
module devctl_buf #(
  parameter int NUM_BUF = 4,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic                      fill_i,
  input  logic [DATA_W-1:0]         fill_base_i,
  output logic [NUM_BUF*DATA_W-1:0] buf_o
);
  for (genvar g = 0; g < NUM_BUF; g++) begin : g_ent
    logic [DATA_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ent_q <= '0;
      else if (fill_i)                               ent_q <= fill_base_i + DATA_W'(g);
      else if (wr_en_i && (int'(wr_idx_i) == g))     ent_q <= wr_data_i;
    end
    assign buf_o[g*DATA_W +: DATA_W] = ent_q;
  end
endmodule

// File: rtl/poll_dev_ctrl.sv
module poll_dev_ctrl
  import devctl_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int BUS_W     = 32,
  parameter int DATA_W    = 8,
  parameter int NUM_BUF   = 4,
  parameter int OP_CYCLES = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic                      bus_wr_i,
  input  logic                      bus_rd_i,
  input  logic [BUS_W-1:0]          bus_wdata_i,
  output logic [BUS_W-1:0]          bus_rdata_o,
  output logic                      irq_o,
  output logic                      out_valid_o,
  output logic [NUM_BUF*DATA_W-1:0] out_data_o
);
  localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
  localparam int FLAT_W = NUM_BUF * DATA_W;

  logic              busy, done, finish;
  logic              cmd_wr, stat_wr, dat_wr, in_dat;
  logic              accept, ack, op_ok;
  op_e               op_in, op_q;
  logic              ie_q;
  logic [3:0]        err_q;
  logic [DATA_W-1:0] xfer_q;
  logic [ADDR_W-1:0] dat_off;
  logic [IDX_W-1:0]  dat_idx;
  logic [FLAT_W-1:0] buf_flat;
  logic [BUS_W-1:0]  rd_word;

  assign dat_off = bus_addr_i - ADDR_W'(DATA_BASE);
  assign dat_idx = dat_off[IDX_W-1:0];
  assign in_dat  = (bus_addr_i >= ADDR_W'(DATA_BASE)) && (dat_off < ADDR_W'(NUM_BUF));
  assign cmd_wr  = bus_wr_i && (bus_addr_i == ADDR_W'(CMD_ADDR));
  assign stat_wr = bus_wr_i && (bus_addr_i == ADDR_W'(STAT_ADDR));
  assign dat_wr  = bus_wr_i && in_dat;
  assign op_in   = op_e'(bus_wdata_i[1:0]);
  assign op_ok   = (op_in == OP_READ) || (op_in == OP_WRITE);
  assign accept  = cmd_wr && !busy && !done && op_ok;
  assign ack     = stat_wr && bus_wdata_i[ACK_BIT];
  assign irq_o   = done && ie_q;

  devctl_seq #(.OP_CYCLES(OP_CYCLES)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .ack_i   (ack),
    .busy_o  (busy),
    .done_o  (done),
    .finish_o(finish)
  );

  devctl_buf #(.NUM_BUF(NUM_BUF), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (dat_wr && !busy),
    .wr_idx_i   (dat_idx),
    .wr_data_i  (bus_wdata_i[DATA_W-1:0]),
    .fill_i     (finish && (op_q == OP_READ)),
    .fill_base_i(DATA_W'(int'(xfer_q) * NUM_BUF)),
    .buf_o      (buf_flat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_NONE;
      ie_q   <= 1'b0;
      err_q  <= ERR_NONE;
      xfer_q <= '0;
    end else begin
      if (accept) begin
        op_q <= op_in;
        ie_q <= bus_wdata_i[IE_BIT];
      end
      // a rejected command outranks a same-edge acknowledge
      if (cmd_wr && (busy || done)) err_q <= ERR_REJECT;
      else if (cmd_wr && !op_ok)    err_q <= ERR_BADOP;
      else if (accept || ack)       err_q <= ERR_NONE;
      if (finish) xfer_q <= xfer_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= finish && (op_q == OP_WRITE);
      if (finish && (op_q == OP_WRITE)) out_data_o <= buf_flat;
    end
  end

  always_comb begin
    rd_word = '0;
    if (bus_addr_i == ADDR_W'(CMD_ADDR)) begin
      rd_word[1:0]    = op_q;
      rd_word[IE_BIT] = ie_q;
    end else if (bus_addr_i == ADDR_W'(STAT_ADDR)) begin
      rd_word[0]   = busy;
      rd_word[1]   = done;
      rd_word[7:4] = err_q;
    end else if (in_dat) begin
      rd_word[DATA_W-1:0] = buf_flat[int'(dat_idx)*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_word;
  end
endmodule

// File: rtl/poll_dev_ctrl_chk.sv
module poll_dev_ctrl_chk
  import devctl_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int BUS_W     = 32,
  parameter int OP_CYCLES = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy,
  input logic              done,
  input logic              accept,
  input logic              cmd_wr,
  input logic [3:0]        err_q,
  input logic              irq_o,
  input logic              out_valid_o,
  input logic              bus_rd_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [BUS_W-1:0]  bus_rdata_o
);
  int run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  assert_flags_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy && done));
  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy);
  assert_busy_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (run_q == OP_CYCLES));
  assert_fall_sets_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> done);
  assert_done_from_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done) |-> $past(busy));
  assert_reject_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && (busy || done)) |=> (err_q == ERR_REJECT));
  assert_out_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
  assert_irq_needs_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done);
  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> $stable(bus_rdata_o));
  assert_stat_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && (bus_addr_i == ADDR_W'(STAT_ADDR))) |=> (bus_rdata_o[1:0] == $past({done, busy})));
endmodule

bind poll_dev_ctrl poll_dev_ctrl_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .OP_CYCLES(OP_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy       (busy),
  .done       (done),
  .accept     (accept),
  .cmd_wr     (cmd_wr),
  .err_q      (err_q),
  .irq_o      (irq_o),
  .out_valid_o(out_valid_o),
  .bus_rd_i   (bus_rd_i),
  .bus_addr_i (bus_addr_i),
  .bus_rdata_o(bus_rdata_o)
);

// File: tb/poll_dev_ctrl_tb_top.sv
`timescale 1ns/1ps
module poll_dev_ctrl_tb_top;
  localparam int NB = 4;
  localparam int OPC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, outv;
  logic [31:0] outd;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  poll_dev_ctrl #(.NUM_BUF(NB), .OP_CYCLES(OPC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr_en),
    .bus_rd_i(rd_en), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .out_valid_o(outv), .out_data_o(outd)
  );

  // reference model
  bit m_busy = 0, m_done = 0, m_ie = 0, m_outv = 0;
  int m_cnt = 0, m_err = 0, m_op = 0, m_xfer = 0;
  logic [7:0]  m_buf [NB];
  logic [31:0] m_rd = '0, m_outd = '0;
  initial for (int i = 0; i < NB; i++) m_buf[i] = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_ie = 0; m_outv = 0; m_cnt = 0;
      m_err = 0; m_op = 0; m_xfer = 0; m_rd = '0; m_outd = '0;
      for (int i = 0; i < NB; i++) m_buf[i] = '0;
    end else begin
      bit ob, od; int a; int op;
      ob = m_busy; od = m_done; a = int'(addr); op = int'(wdata[1:0]);
      if (rd_en) begin
        if (a == 0)                    m_rd = 32'(m_op | (int'(m_ie) << 4));
        else if (a == 1)               m_rd = 32'(int'(m_busy) | (int'(m_done) << 1) | (m_err << 4));
        else if (a >= 2 && a < 2 + NB) m_rd = {24'b0, m_buf[a-2]};
        else                           m_rd = '0;
      end
      m_outv = 0;
      if (ob) begin
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          if (m_op == 1) for (int i = 0; i < NB; i++) m_buf[i] = 8'(m_xfer * NB + i);
          if (m_op == 2) begin
            m_outv = 1;
            m_outd = {m_buf[3], m_buf[2], m_buf[1], m_buf[0]};
          end
          m_xfer++;
        end else m_cnt--;
      end
      if (wr_en && a >= 2 && a < 2 + NB && !ob) m_buf[a-2] = wdata[7:0];
      if (wr_en && a == 1 && wdata[1]) begin
        if (od) m_done = 0;
        m_err = 0;
      end
      if (wr_en && a == 0) begin
        if (ob || od) m_err = 1;
        else if (op == 0 || op == 3) m_err = 2;
        else begin
          m_busy = 1; m_cnt = OPC - 1; m_op = op; m_ie = wdata[4]; m_err = 0;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", req, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    chk({cur_req, " rdata"}, rdata, m_rd);
    chk({cur_req, " irq"}, {31'b0, irq}, {31'b0, m_ie && m_done});
    chk({cur_req, " out_valid"}, {31'b0, outv}, {31'b0, m_outv});
    chk({cur_req, " out_data"}, outd, m_outd);
  end

  logic [31:0] last_out = '0;
  always @(negedge clk) if (outv) last_out = outd;

  task automatic wr(input int a, input int d);
    addr = 4'(a); wdata = 32'(d); wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a);
    addr = 4'(a); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 50; k++) begin
      rd(1);
      if (rdata[1]) return;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    rd(1); chk("R1 status", rdata, 32'h0);
    rd(0); chk("R1 cmd", rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    cur_req = "R2";
    wr(0, 32'h11);
    rd(1); chk("R2 busy", rdata, 32'h01);
    cur_req = "R3";
    wait_done(); chk("R3 done", rdata, 32'h02);
    cur_req = "R9";
    chk("R9 irq with enable", {31'b0, irq}, 32'h1);
    cur_req = "R7";
    for (int i = 0; i < NB; i++) begin
      rd(2 + i); chk("R7 fill k=0", rdata, 32'(i));
    end
    cur_req = "R6";
    wr(1, 32'h2);
    chk("R9 irq cleared", {31'b0, irq}, 32'h0);
    rd(1); chk("R6 ack", rdata, 32'h0);

    cur_req = "R11";
    for (int i = 0; i < NB; i++) wr(2 + i, 32'h10 + i);
    wr(0, 32'h02);
    wr(2, 32'hFF);
    cur_req = "R4";
    wr(0, 32'h11);
    rd(1); chk("R4 reject busy", rdata, 32'h11);
    cur_req = "R8";
    wait_done(); chk("R3 done err kept", rdata, 32'h12);
    chk("R8 out_data", last_out, 32'h13121110);
    chk("R11 data write blocked", last_out[7:0], 32'h10);
    chk("R9 irq without enable", {31'b0, irq}, 32'h0);
    cur_req = "R4";
    wr(0, 32'h01);
    rd(1); chk("R4 reject done", rdata, 32'h12);
    rd(0); chk("R4 cmd kept", rdata, 32'h02);
    cur_req = "R6";
    wr(1, 32'h2);
    rd(1); chk("R6 ack clears err", rdata, 32'h0);

    cur_req = "R5";
    wr(0, 32'h13);
    rd(1); chk("R5 bad opcode", rdata, 32'h20);
    wr(0, 32'h10);
    rd(1); chk("R5 opcode zero", rdata, 32'h20);
    wr(1, 32'h2);

    cur_req = "R7";
    wr(0, 32'h01);
    wait_done(); chk("R3 second done", rdata, 32'h02);
    for (int i = 0; i < NB; i++) begin
      rd(2 + i); chk("R7 fill k=2", rdata, 32'(8 + i));
    end

    cur_req = "R10";
    rd(15); chk("R10 unmapped", rdata, 32'h0);
    rd(3);
    repeat (3) @(negedge clk);
    chk("R10 hold", rdata, 32'h09);
    rd(1); chk("R10 status read", rdata, 32'h02);
    rd(1); chk("R10 no side effect", rdata, 32'h02);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule